// File: doc/BRIEF.md
# Connection-Memory Control-Bit Output Sequencer

This block keeps one control entry for every time slot of a serial switch: eight transmit streams, each with 32 channels of eight bits, which gives 256 entries. Every entry holds two bits. The first bit is a drive-enable flag. It decides whether that stream's transmit pin is driven or left floating during that channel. The second bit is a control flag. A free-running bit counter is aligned to the transmit streams by a frame-sync input. From that counter the block produces registered per-stream tri-state enables and one serial control-bit stream. The control-bit stream sends all 256 control flags once per frame.

The control-bit stream runs one channel ahead of the transmit data. During the eight bit periods of channel c, it sends the control flags of channel c+1 for streams 0 to 7 in that order. This gives external circuitry a full channel of warning. A global drive-enable input forces every transmit enable low, whatever the stored entries hold. The store is not cleared by reset, so software keeps the global enable low until it has written every entry. Writes go through a single-port store that the sequencer also reads. The sequencer reads it once per channel, and the write port is refused only in that cycle.

Top module: `csq_ctl_sequencer`

## Requirements
- R1: While reset is asserted, `tx_oe` is all zeros and `ctl_out` is 0.
- R2: When `out_drive_en` is low at the clock edge that starts a bit period, `tx_oe` is all zeros for that bit period, whatever the stored enables hold.
- R3: When `out_drive_en` is high, `tx_oe[s]` equals the drive-enable flag of stream s for the current channel. It changes only on the edge that starts bit position 0 of a channel.
- R4: In bit position p (0 to 7, where position 0 is the first bit of a channel) of channel c, `ctl_out` carries the control flag of stream p, channel (c+1) mod 32. Channel 31 therefore carries channel 0 of the next frame.
- R5: A frame is 256 bit periods. The counter wraps from the last bit of channel 31 to channel 0, position 0. A high `frame_sync` at a clock edge makes the next bit period channel 0, position 0.
- R6: After a `frame_sync` that arrives at any point in the frame, `ctl_out` is correct from the first bit period that follows. `tx_oe` is correct from channel 1 onward.
- R7: `wr_ready` is low in exactly one cycle of each channel: the last bit period, which comes before the edge into the next channel. It is also low in any cycle in which `frame_sync` is high.
- R8: A write with `wr_en` and `wr_ready` both high at a clock edge stores `wr_oe` and `wr_cco` into entry (`wr_stream`, `wr_chan`). The new values appear at the outputs the next time that channel is fetched. A write presented while `wr_ready` is low is dropped and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one cycle per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_sync | input | 1 | Realigns the counter to channel 0, position 0 |
| out_drive_en | input | 1 | Global drive enable; low forces all transmit enables off |
| wr_en | input | 1 | Write request for one entry |
| wr_stream | input | 3 | Stream index of the entry being written |
| wr_chan | input | 5 | Channel index of the entry being written |
| wr_oe | input | 1 | Drive-enable flag to store |
| wr_cco | input | 1 | Control flag to store |
| wr_ready | output | 1 | High when a write is accepted at the next edge |
| tx_oe | output | 8 | Per-stream tri-state enables, registered |
| ctl_out | output | 1 | Serial control-bit stream, one channel ahead |

## Verification
The bench checks whole frames bit by bit against a model of the store. This catches a design that sends the control flags of the current channel instead of the next one, or that gets the order of streams within a channel wrong. Channel 31 is checked to carry channel 0's flags, so a design that fails to wrap the one-channel lead would show up there. Two frame syncs are issued: one in the middle of a frame, and one before two back-to-back frames that test the natural wrap. Together they show whether a design loses the lookahead fetch or the free-running alignment. A write issued in the one refused cycle must leave the entry unchanged, and a frame with the global enable low must show no enables at all.

// File: rtl/csq_pkg.sv
package csq_pkg;

  // One connection entry: drive-enable flag and serial control flag.
  typedef struct packed {
    logic cco;
    logic oe;
  } conn_ent_t;

endpackage

// File: rtl/csq_frame_timer.sv
module csq_frame_timer #(
  parameter  int NUM_CHANS   = 32,
  parameter  int SLOT_BITS   = 8,
  localparam int FRAME_LEN   = NUM_CHANS * SLOT_BITS,
  localparam int CNT_W       = $clog2(FRAME_LEN),
  localparam int POS_W       = $clog2(SLOT_BITS),
  localparam int CHAN_W      = $clog2(NUM_CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  output logic [CHAN_W-1:0] next_chan,
  output logic [POS_W-1:0]  next_pos,
  output logic              chan_edge
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (frame_sync) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  // Reset value puts the first edge on a channel boundary into channel 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(FRAME_LEN - 1);
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign next_chan = cnt_d[CNT_W-1:POS_W];
  assign next_pos  = cnt_d[POS_W-1:0];
  assign chan_edge = (next_pos == '0);

  // R5
  fs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (cnt_q == '0));

  // R5
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && cnt_q == CNT_W'(FRAME_LEN - 1)) |=> (cnt_q == '0));

endmodule

// File: rtl/csq_conn_store.sv
module csq_conn_store
  import csq_pkg::*;
#(
  parameter  int NUM_STREAMS = 8,
  parameter  int NUM_CHANS   = 32,
  localparam int SW          = $clog2(NUM_STREAMS),
  localparam int CW          = $clog2(NUM_CHANS)
) (
  input  logic                         clk,
  input  logic                         seq_rd,
  input  logic [CW-1:0]                seq_chan,
  input  logic                         wr_en,
  input  logic [SW-1:0]                wr_stream,
  input  logic [CW-1:0]                wr_chan,
  input  logic                         wr_oe,
  input  logic                         wr_cco,
  output conn_ent_t [NUM_STREAMS-1:0]  seq_word,
  output logic                         wr_ready
);

  // One word per channel, one lane per stream; single shared port.
  conn_ent_t [NUM_STREAMS-1:0] mem_q [NUM_CHANS];

  logic          wr_go;
  logic [CW-1:0] port_addr;
  conn_ent_t     wr_ent;

  assign wr_ready  = ~seq_rd;
  assign wr_go     = wr_en & ~seq_rd;
  assign port_addr = seq_rd ? seq_chan : wr_chan;
  assign wr_ent    = '{cco: wr_cco, oe: wr_oe};

  // Contents are not reset: software programs them before enabling drive.
  always_ff @(posedge clk) begin
    if (wr_go) begin
      mem_q[port_addr][wr_stream] <= wr_ent;
    end
  end

  assign seq_word = seq_rd ? mem_q[port_addr] : '0;

endmodule

// File: rtl/csq_ctl_serializer.sv
module csq_ctl_serializer
  import csq_pkg::*;
#(
  parameter  int NUM_STREAMS = 8,
  localparam int SW          = $clog2(NUM_STREAMS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         out_drive_en,
  input  logic                         chan_edge,
  input  logic [SW-1:0]                next_pos,
  input  conn_ent_t [NUM_STREAMS-1:0]  fetch_word,
  output logic [NUM_STREAMS-1:0]       tx_oe,
  output logic                         ctl_bit
);

  // ahead_q holds the word of the channel after the one now on the line.
  conn_ent_t [NUM_STREAMS-1:0] ahead_q;
  logic [NUM_STREAMS-1:0]      ahead_oe;
  logic [NUM_STREAMS-1:0]      slot_oe_q;
  logic [NUM_STREAMS-1:0]      slot_oe_d;
  logic [NUM_STREAMS-1:0]      oe_q;
  logic [NUM_STREAMS-1:0]      oe_d;
  logic                        cco_q;
  logic                        cco_d;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_oe_lane
    assign ahead_oe[s] = ahead_q[s].oe;
  end

  always_comb begin
    slot_oe_d = chan_edge ? ahead_oe : slot_oe_q;
    oe_d      = out_drive_en ? slot_oe_d : '0;
    cco_d     = chan_edge ? fetch_word[0].cco : ahead_q[next_pos].cco;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ahead_q   <= '0;
      slot_oe_q <= '0;
    end else if (chan_edge) begin
      ahead_q   <= fetch_word;
      slot_oe_q <= slot_oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= '0;
      cco_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      cco_q <= cco_d;
    end
  end

  assign tx_oe   = oe_q;
  assign ctl_bit = cco_q;

  // R2
  drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_drive_en |=> (tx_oe == '0));

  // R3
  oe_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_edge && out_drive_en && tx_oe != '0) |=> $stable(tx_oe));

  // R4
  lead_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_edge |=> (ctl_bit == $past(fetch_word[0].cco)));

endmodule

// File: rtl/csq_ctl_sequencer.sv
module csq_ctl_sequencer
  import csq_pkg::*;
#(
  parameter  int NUM_STREAMS = 8,
  parameter  int NUM_CHANS   = 32,
  localparam int SW          = $clog2(NUM_STREAMS),
  localparam int CW          = $clog2(NUM_CHANS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_sync,
  input  logic                   out_drive_en,
  input  logic                   wr_en,
  input  logic [SW-1:0]          wr_stream,
  input  logic [CW-1:0]          wr_chan,
  input  logic                   wr_oe,
  input  logic                   wr_cco,
  output logic                   wr_ready,
  output logic [NUM_STREAMS-1:0] tx_oe,
  output logic                   ctl_out
);

  logic [1:0]                  rst_sync_q;
  logic                        rst_core_n;
  logic [CW-1:0]               next_chan;
  logic [SW-1:0]               next_pos;
  logic                        chan_edge;
  logic [CW-1:0]               fetch_chan;
  conn_ent_t [NUM_STREAMS-1:0] fetch_word;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  // Fetch two channels ahead of the one now on the line.
  assign fetch_chan = next_chan + CW'(1);

  csq_frame_timer #(
    .NUM_CHANS (NUM_CHANS),
    .SLOT_BITS (NUM_STREAMS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .frame_sync (frame_sync),
    .next_chan  (next_chan),
    .next_pos   (next_pos),
    .chan_edge  (chan_edge)
  );

  csq_conn_store #(
    .NUM_STREAMS (NUM_STREAMS),
    .NUM_CHANS   (NUM_CHANS)
  ) u_store (
    .clk       (clk),
    .seq_rd    (chan_edge),
    .seq_chan  (fetch_chan),
    .wr_en     (wr_en),
    .wr_stream (wr_stream),
    .wr_chan   (wr_chan),
    .wr_oe     (wr_oe),
    .wr_cco    (wr_cco),
    .seq_word  (fetch_word),
    .wr_ready  (wr_ready)
  );

  csq_ctl_serializer #(
    .NUM_STREAMS (NUM_STREAMS)
  ) u_ser (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .out_drive_en (out_drive_en),
    .chan_edge    (chan_edge),
    .next_pos     (next_pos),
    .fetch_word   (fetch_word),
    .tx_oe        (tx_oe),
    .ctl_bit      (ctl_out)
  );

  // R7
  port_gap_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !wr_ready |=> (wr_ready || frame_sync));

endmodule

// File: tb/tb_csq_ctl_sequencer.sv
module tb_csq_ctl_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NS         = 8;
  localparam int NC         = 32;
  localparam int FRAME      = NS * NC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_sync;
  logic          out_drive_en;
  logic          wr_en;
  logic [2:0]    wr_stream;
  logic [4:0]    wr_chan;
  logic          wr_oe;
  logic          wr_cco;
  logic          wr_ready;
  logic [NS-1:0] tx_oe;
  logic          ctl_out;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [NS-1:0] oe;
    logic          cco;
    bit            chk_oe;
    string         oe_tag;
    string         cco_tag;
    int            slot;
  } exp_t;

  exp_t exp_q[$];
  bit   ref_oe  [NS][NC];
  bit   ref_cco [NS][NC];

  always #(CLK_PERIOD / 2) clk = ~clk;

  csq_ctl_sequencer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_sync   (frame_sync),
    .out_drive_en (out_drive_en),
    .wr_en        (wr_en),
    .wr_stream    (wr_stream),
    .wr_chan      (wr_chan),
    .wr_oe        (wr_oe),
    .wr_cco       (wr_cco),
    .wr_ready     (wr_ready),
    .tx_oe        (tx_oe),
    .ctl_out      (ctl_out)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Monitor: pops one expected item per bit period, away from the edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.chk_oe) begin
          checks++;
          if (tx_oe !== e.oe) begin
            errors++;
            $display("FAIL %s tx_oe slot %0d: actual %0h expected %0h",
                     e.oe_tag, e.slot, tx_oe, e.oe);
          end
        end
        checks++;
        if (ctl_out !== e.cco) begin
          errors++;
          $display("FAIL %s ctl_out slot %0d: actual %0b expected %0b",
                   e.cco_tag, e.slot, ctl_out, e.cco);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic write_entry(int s, int c, bit oe, bit cco);
    @(negedge clk);
    wr_stream = 3'(s);
    wr_chan   = 5'(c);
    wr_oe     = oe;
    wr_cco    = cco;
    wr_en     = 1'b1;
    #1;
    while (!wr_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_all(int pat);
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < NS; s++) begin
        bit o;
        bit k;
        if (pat == 0) begin
          o = ((s + c) % 3) == 0;
          k = ((s * 5 + c) % 2) == 1;
        end else begin
          o = (s == (c % NS)) || (c >= 28);
          k = ((c * 3 + s) % 7) < 3;
        end
        ref_oe[s][c]  = o;
        ref_cco[s][c] = k;
        write_entry(s, c, o, k);
      end
    end
  endtask

  // Pulse frame sync, then let one full frame pass so the lookahead fills.
  task automatic align();
    @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    repeat (FRAME) @(negedge clk);
  endtask

  // Called at the negedge where slot 0 is on the outputs.
  task automatic push_frame(string oe_tag, string cco_tag, bit ode, int skip_oe);
    for (int n = 0; n < FRAME; n++) begin
      exp_t e;
      int   c;
      int   p;
      c = n / NS;
      p = n % NS;
      for (int s = 0; s < NS; s++) begin
        e.oe[s] = ode ? ref_oe[s][c] : 1'b0;
      end
      e.cco     = ref_cco[p][(c + 1) % NC];
      e.chk_oe  = (n >= skip_oe);
      e.oe_tag  = oe_tag;
      e.cco_tag = cco_tag;
      e.slot    = n;
      exp_q.push_back(e);
    end
    repeat (FRAME) @(negedge clk);
  endtask

  initial begin
    rst_n        = 1'b0;
    frame_sync   = 1'b0;
    out_drive_en = 1'b0;
    wr_en        = 1'b0;
    wr_stream    = '0;
    wr_chan      = '0;
    wr_oe        = 1'b0;
    wr_cco       = 1'b0;

    // R1: outputs quiet while reset is held
    repeat (4) @(negedge clk);
    #1;
    check_val("R1 tx_oe in reset", 32'(tx_oe), 32'h0);
    check_val("R1 ctl_out in reset", 32'(ctl_out), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Program with the global enable low
    write_all(0);

    // R2: drive disabled, control stream still runs (R4)
    align();
    push_frame("R2", "R4", 1'b0, 0);

    // R3 and R4 with drive enabled
    out_drive_en = 1'b1;
    align();
    push_frame("R3", "R4", 1'b1, 0);

    // R7: port refusal exactly at the last bit of each channel
    begin
      int lows;
      int misplaced;
      lows      = 0;
      misplaced = 0;
      for (int n = 0; n < FRAME; n++) begin
        #1;
        if (!wr_ready) lows++;
        if (wr_ready == ((n % NS) == NS - 1)) misplaced++;
        @(negedge clk);
      end
      check_val("R7 refused cycles per frame", 32'(lows), 32'(NC));
      check_val("R7 refused cycles off position", 32'(misplaced), 32'h0);
    end

    // R8: a write offered only in a refused cycle is dropped
    begin
      @(negedge clk);
      #1;
      while (wr_ready) begin
        @(negedge clk);
        #1;
      end
      wr_stream = 3'd3;
      wr_chan   = 5'd5;
      wr_oe     = ~ref_oe[3][5];
      wr_cco    = ~ref_cco[3][5];
      wr_en     = 1'b1;
      @(negedge clk);
      wr_en     = 1'b0;
    end
    align();
    push_frame("R8", "R8", 1'b1, 0);

    // R6: frame sync in mid-frame; control stream right at once
    repeat (100) @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    push_frame("R6", "R6", 1'b1, NS);

    // R8: rewrite everything while the outputs run
    write_all(1);
    align();
    push_frame("R8", "R8", 1'b1, 0);

    // R5: next frame with no sync, free-running wrap
    push_frame("R5", "R5", 1'b1, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule